// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Engine

This block is the bus-facing engine of a byte-addressed serial EEPROM that sits on an I2C bus as a slave. It watches SCL and SDA, which it oversamples with its own clock. It finds start and stop conditions and compares each control byte with a fixed four-bit device code and three strap inputs. It answers only when the control byte matches. A write transfer carries a two-byte word address and then data bytes, which go into an internal register-array memory. A read transfer returns bytes from a persistent address pointer. Reads and writes share this pointer, and it always holds the location after the last byte accessed.

When a stop closes a transfer that stored at least one data byte, the engine enters a self-timed busy phase that lasts `WRITE_CYCLES` clocks. During that phase it ignores the bus completely, and control bytes go unacknowledged. A master can therefore poll for the end of the write. Three kinds of read are possible. A current read uses the pointer as it stands. A random read first loads the pointer with a dummy write and then sends a repeated start. A sequential read goes on byte after byte while the master keeps acknowledging.

States: `ST_IDLE` (released, waiting for a start), `ST_CTRL` (control byte in), `ST_CTRL_ACK`, `ST_AHI` / `ST_AHI_ACK` (address high byte), `ST_ALO` / `ST_ALO_ACK` (address low byte), `ST_WDATA` / `ST_WACK` (write data), `ST_RDATA` (data out), `ST_RACK` (master acknowledge slot) and `ST_BUSY` (self-timed write).

Transitions:
- A start moves any state except `ST_BUSY` to `ST_CTRL`.
- A stop moves any state except `ST_BUSY` to `ST_BUSY` when data was stored, and to `ST_IDLE` otherwise.
- `ST_CTRL` goes to `ST_CTRL_ACK` on a match and to `ST_IDLE` on a mismatch.
- `ST_CTRL_ACK` goes to `ST_RDATA` for a read and to `ST_AHI` for a write.
- The address path runs `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDATA`.
- The write loop runs `ST_WDATA` ⇄ `ST_WACK`.
- `ST_RDATA` goes to `ST_RACK`. `ST_RACK` goes back to `ST_RDATA` on a master ACK and to `ST_IDLE` on a NACK.
- `ST_BUSY` goes to `ST_IDLE` when its timer expires.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A control byte whose upper seven bits equal 1010 followed by `chip_sel[2:0]` (MSB first, R/W in bit 0) is acknowledged by pulling SDA low in the ninth clock. Any other control byte gets no acknowledge, and SDA stays released until the next start.
- R2: In a write transfer the high address byte comes first and the low byte second. Only the low four bits of the high byte are used. Each following data byte is stored at the pointer, the pointer advances by one, and every byte is acknowledged.
- R3: A stop after at least one stored data byte starts a busy phase of `WRITE_CYCLES` clocks. During it SDA is never driven, nothing is written, and a control byte is not acknowledged.
- R4: Once the busy phase ends, a matching control byte is acknowledged again.
- R5: A control byte with R/W = 1 and no preceding address is a current read. It returns the byte at the pointer, which holds the last accessed location plus one after either a read or a write.
- R6: A random read loads the pointer from the two address bytes. The repeated start that follows ends the write without storing anything, and the next read control byte returns the byte at the loaded address.
- R7: A master ACK after a read byte makes the engine send the byte at the next address. The pointer wraps from 4095 to 0, for reads and for writes alike.
- R8: After a master NACK and a stop, SDA is released.
- R9: A start or stop in the middle of a byte drops the partial byte, leaves the pointer unchanged and returns the engine to waiting for a control byte.
- R10: After reset SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| chip_sel | input | 3 | Strap value matched against control-byte bits 3:1 |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |

## Verification
A wrong state shows up on the bus within one SCL period. It appears as an acknowledge in the wrong ninth-clock slot, as a missing acknowledge, or as SDA held low so that the next start or stop cannot form. A bad pointer does not show at once. It appears in the next read byte, which is why every write scenario is followed by a random, current or sequential read of known values. A busy phase that is too short or too long shows as a poll that is acknowledged or refused at the wrong time.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } eep_state_t;

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_q;
    logic [2:0] sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    always_comb begin
        sda_s     = sda_q[1];
        scl_rise  = scl_q[1] & ~scl_q[2];
        scl_fall  = ~scl_q[1] & scl_q[2];
        start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
        stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
    end
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
    import eeprom_pkg::*;
#(
    parameter int         ADDR_W       = 12,
    parameter int         WRITE_CYCLES = 5000,
    parameter logic [3:0] DEV_CODE     = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_sel,
    output logic       sda_oe
);
    localparam int HI_W = ADDR_W - 8;
    localparam int TW   = $clog2(WRITE_CYCLES + 1);

    eep_state_t        state;
    logic [7:0]        rx_sr;
    logic [7:0]        tx_sr;
    logic [3:0]        bit_cnt;
    logic [ADDR_W-1:0] ptr;
    logic [HI_W-1:0]   addr_hi;
    logic              wrote;
    logic              rd_mode;
    logic              m_ack;
    logic [TW-1:0]     wt_cnt;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic mem_we, byte_end, ctrl_match, rx_phase;
    logic [7:0] mem_rdata;

    i2c_line_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    eeprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(ptr),
        .wdata(rx_sr),
        .raddr(ptr),
        .rdata(mem_rdata)
    );

    always_comb begin
        byte_end   = scl_fall && (bit_cnt == 4'd8);
        ctrl_match = (rx_sr[7:1] == {DEV_CODE, chip_sel});
        rx_phase   = (state == ST_CTRL) || (state == ST_AHI) ||
                     (state == ST_ALO)  || (state == ST_WDATA);
        mem_we     = (state == ST_WDATA) && byte_end;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rx_sr   <= '0;
            tx_sr   <= '0;
            bit_cnt <= '0;
            ptr     <= '0;
            addr_hi <= '0;
            wrote   <= 1'b0;
            rd_mode <= 1'b0;
            m_ack   <= 1'b0;
            wt_cnt  <= '0;
        end else if (state == ST_BUSY) begin
            if (wt_cnt == '0) state <= ST_IDLE;
            else              wt_cnt <= wt_cnt - 1'b1;
        end else if (start_det) begin
            state   <= ST_CTRL;
            bit_cnt <= '0;
            wrote   <= 1'b0;
        end else if (stop_det) begin
            if (wrote) begin
                state  <= ST_BUSY;
                wt_cnt <= TW'(WRITE_CYCLES - 1);
                wrote  <= 1'b0;
            end else begin
                state <= ST_IDLE;
            end
        end else begin
            if (scl_rise && rx_phase && bit_cnt < 4'd8) begin
                rx_sr   <= {rx_sr[6:0], sda_s};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_rise && state == ST_RACK) m_ack <= ~sda_s;
            if (scl_fall) begin
                unique case (state)
                    ST_CTRL: if (byte_end) begin
                        if (ctrl_match) begin
                            state   <= ST_CTRL_ACK;
                            rd_mode <= rx_sr[0];
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    ST_CTRL_ACK: begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            tx_sr <= mem_rdata;
                            ptr   <= ptr + 1'b1;
                            state <= ST_RDATA;
                        end else begin
                            state <= ST_AHI;
                        end
                    end
                    ST_AHI: if (byte_end) begin
                        addr_hi <= rx_sr[HI_W-1:0];
                        state   <= ST_AHI_ACK;
                    end
                    ST_AHI_ACK: begin
                        bit_cnt <= '0;
                        state   <= ST_ALO;
                    end
                    ST_ALO: if (byte_end) begin
                        ptr   <= {addr_hi, rx_sr};
                        state <= ST_ALO_ACK;
                    end
                    ST_ALO_ACK, ST_WACK: begin
                        bit_cnt <= '0;
                        state   <= ST_WDATA;
                    end
                    ST_WDATA: if (byte_end) begin
                        ptr   <= ptr + 1'b1;
                        wrote <= 1'b1;
                        state <= ST_WACK;
                    end
                    ST_RDATA: begin
                        if (bit_cnt == 4'd7) begin
                            state <= ST_RACK;
                        end else begin
                            tx_sr   <= {tx_sr[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (m_ack) begin
                            tx_sr   <= mem_rdata;
                            ptr     <= ptr + 1'b1;
                            bit_cnt <= '0;
                            state   <= ST_RDATA;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_CTRL_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~tx_sr[7];
            default:  sda_oe = 1'b0;
        endcase
    end

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> !sda_oe); // R3
    AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY) |-> !mem_we); // R3
    AST_STOP_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && wrote && state != ST_BUSY) |=> (state == ST_BUSY)); // R3
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe); // R8
    AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL && byte_end && !start_det && !stop_det && !ctrl_match)
        |=> (state == ST_IDLE)); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && $past(state) == ST_RACK)
        |-> (ptr == ADDR_W'($past(ptr) + 1'b1))); // R7
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
    localparam int H = 10;
    localparam int Q = 4;
    localparam int WCYC = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_pull = 1'b0;
    logic dut_oe;
    logic sda_bus;
    logic [2:0] cs = 3'b101;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    assign sda_bus = !(m_pull || dut_oe);

    i2c_eeprom_slave #(.ADDR_W(12), .WRITE_CYCLES(WCYC)) u_i2c_eeprom_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .chip_sel(cs),
        .sda_oe  (dut_oe)
    );

    localparam logic [7:0] CW = 8'hAA; // 1010 101 0
    localparam logic [7:0] CR = 8'hAB; // 1010 101 1

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_pull = 1'b0; w(H); m_scl = 1'b1; w(H);
        m_pull = 1'b1; w(H); m_scl = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        m_pull = 1'b1; w(H); m_scl = 1'b1; w(H);
        m_pull = 1'b0; w(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_pull = !b[7-i]; w(H);
            m_scl = 1'b1; w(H);
            m_scl = 1'b0; w(Q);
        end
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_pull = 1'b0; w(H);
        m_scl = 1'b1; w(H/2);
        ack = !sda_bus; w(H/2);
        m_scl = 1'b0; w(Q);
    endtask

    task automatic rd_byte(input bit give_ack, output logic [7:0] b);
        m_pull = 1'b0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            w(H); m_scl = 1'b1; w(H/2);
            b = {b[6:0], sda_bus}; w(H/2);
            m_scl = 1'b0; w(Q);
        end
        m_pull = give_ack; w(H);
        m_scl = 1'b1; w(H);
        m_scl = 1'b0; w(Q);
        m_pull = 1'b0;
    endtask

    task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        bit a;
        bus_start();
        wr_byte(CW, a); chk(a, req, a, 1);
        wr_byte(hi, a); chk(a, req, a, 1);
        wr_byte(lo, a); chk(a, req, a, 1);
    endtask

    task automatic t_reset();
        w(3);
        chk(dut_oe == 1'b0, "R10 reset sda released", dut_oe, 0);
    endtask

    task automatic t_foreign_addr();
        bit a;
        bus_start();
        wr_byte(8'hA0, a);
        chk(!a, "R1 foreign address not acked", a, 0);
        chk(dut_oe == 1'b0, "R1 foreign address bus released", dut_oe, 0);
        bus_stop();
    endtask

    task automatic t_page_write();
        bit a;
        set_addr(8'h01, 8'h23, "R1 R2 address phase ack");
        wr_byte(8'h11, a); chk(a, "R2 data ack", a, 1);
        wr_byte(8'h22, a); chk(a, "R2 data ack", a, 1);
        wr_byte(8'h33, a); chk(a, "R2 data ack", a, 1);
        bus_stop();
    endtask

    task automatic t_ack_poll();
        bit a;
        bus_start();
        wr_byte(CW, a);
        chk(!a, "R3 no ack while busy", a, 0);
        bus_stop();
        w(WCYC + 100);
        bus_start();
        wr_byte(CW, a);
        chk(a, "R4 ack after write cycle", a, 1);
        bus_stop();
    endtask

    task automatic t_random_read();
        bit a;
        logic [7:0] d;
        set_addr(8'h01, 8'h24, "R6 dummy write ack");
        bus_start();
        wr_byte(CR, a); chk(a, "R6 read control ack", a, 1);
        rd_byte(1'b0, d);
        chk(d == 8'h22, "R6 random read data", d, 8'h22);
        bus_stop();
        chk(dut_oe == 1'b0, "R8 released after nack and stop", dut_oe, 0);
    endtask

    task automatic t_abort_stop();
        bit a;
        logic [7:0] d;
        bus_start();
        send_bits(8'hA0, 4);
        bus_stop();
        bus_start();
        wr_byte(CR, a); chk(a, "R9 control ack after aborted byte", a, 1);
        rd_byte(1'b0, d);
        chk(d == 8'h33, "R5 R9 current read after abort", d, 8'h33);
        bus_stop();
    endtask

    task automatic t_abort_restart();
        bit a;
        logic [7:0] d;
        set_addr(8'h01, 8'h23, "R9 setup ack");
        bus_start();
        wr_byte(CW, a); chk(a, "R9 second control ack", a, 1);
        send_bits(8'h0F, 3);
        bus_start();
        wr_byte(CR, a); chk(a, "R9 read control ack", a, 1);
        rd_byte(1'b0, d);
        chk(d == 8'h11, "R9 pointer kept after partial address", d, 8'h11);
        bus_stop();
    endtask

    task automatic t_sequential();
        bit a;
        logic [7:0] d;
        set_addr(8'h01, 8'h23, "R7 setup ack");
        bus_start();
        wr_byte(CR, a); chk(a, "R7 read control ack", a, 1);
        rd_byte(1'b1, d); chk(d == 8'h11, "R7 sequential byte 0", d, 8'h11);
        rd_byte(1'b1, d); chk(d == 8'h22, "R7 sequential byte 1", d, 8'h22);
        rd_byte(1'b0, d); chk(d == 8'h33, "R7 sequential byte 2", d, 8'h33);
        bus_stop();
        chk(dut_oe == 1'b0, "R8 released after sequential read", dut_oe, 0);
    endtask

    task automatic t_wrap();
        bit a;
        logic [7:0] d;
        set_addr(8'hFF, 8'hFF, "R2 high nibble ignored ack");
        wr_byte(8'h5A, a); chk(a, "R7 write at top ack", a, 1);
        wr_byte(8'hA5, a); chk(a, "R7 write wrapped ack", a, 1);
        bus_stop();
        w(WCYC + 100);
        set_addr(8'h0F, 8'hFF, "R7 read setup ack");
        bus_start();
        wr_byte(CR, a); chk(a, "R7 read control ack", a, 1);
        rd_byte(1'b1, d); chk(d == 8'h5A, "R2 R7 byte at 4095", d, 8'h5A);
        rd_byte(1'b0, d); chk(d == 8'hA5, "R7 wrapped byte at 0", d, 8'hA5);
        bus_stop();
    endtask

    initial begin
        w(5);
        rst_n = 1'b1;
        t_reset();
        t_foreign_addr();
        t_page_write();
        t_ack_poll();
        t_random_read();
        t_abort_stop();
        t_abort_restart();
        t_sequential();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule